// File: doc/BRIEF.md
# USB Low/Full-Speed Line Receiver

This block turns the raw D+/D- wire pair of a USB low-speed or full-speed link into a stream of single-cycle event strobes. The two wires are first synchronised into the local clock domain and then classified each cycle as one of four line symbols: J, K, SE0 (both wires low) or SE1 (both wires high). A bit-phase counter runs at a fixed oversampling ratio. It realigns on every symbol change so that each bit time is sampled once near its middle. A small state machine watches these samples. It announces the start of a packet, recovers data bits by NRZI decoding, removes stuff bits, and announces the end of a packet.

A speed input selects how the wire levels map to J and K. The two speeds use opposite polarity. Every sampled symbol inside a packet produces a symbol strobe carrying its code. J/K samples also produce either a data-bit strobe with its value or a stuff-bit strobe. SE0, SE1 and the J that closes a packet never yield data bits. The oversampling ratio (clock cycles per bit time) is a fixed parameter. Packet-level parsing sits downstream.

The state machine has three states:
- `ST_IDLE` waits on the idle line.
- `ST_BITS` collects bits.
- `ST_EOPW` waits for the J that ends SE0.

Its transitions are:
- `ST_IDLE`→`ST_BITS` on a change to K.
- `ST_BITS`→`ST_EOPW` on a sampled SE0.
- `ST_EOPW`→`ST_IDLE` on a sampled J.
- `ST_BITS`/`ST_EOPW`→`ST_IDLE` on a sampled SE1.

Top module: `usbrx_top`

## Requirements
- R1: Wire levels map to symbol codes J=0, K=1, SE0=2, SE1=3. The wire levels are (D+,D-)=(0,0) for SE0 and (1,1) for SE1. At full speed (`low_speed_i`=0), (1,0) is J and (0,1) is K; at low speed the mapping is swapped. Symbol strobes report this code on `sym_code_o`.
- R2: Out of reset every output strobe is low. An idle J line, however long, produces no strobe.
- R3: While idle, a change of the line to K raises `sop_o` alone, 3 cycles after the wire change, and enters bit collection.
- R4: Inside a packet each symbol is sampled OSR/2 cycles after the most recent symbol change, then once every OSR cycles while the line holds. `sym_o` for a symbol rises 3+OSR/2 cycles after its wire change, and two `sym_o` pulses are never adjacent.
- R5: For a sampled J or K, the decoded bit is 1 when the symbol equals the previously sampled J/K symbol and 0 otherwise. The previous symbol is taken as J at SOP. A non-stuff bit raises `bit_o` with the value on `bit_val_o`, in the same cycle as `sym_o`.
- R6: A decoded 0 arriving after six consecutive decoded 1s raises `stuff_o` instead of `bit_o` and clears the ones count. Any other decoded 0 also clears the count, and each 1 increments it.
- R7: A sampled SE0 during bit collection raises `sym_o` (code 2) without `bit_o` or `stuff_o` and starts end-of-packet waiting. Further SE0 samples repeat the symbol strobe only.
- R8: A J sampled after SE0 raises `eop_o` together with `sym_o` (code 0) and no data bit. The block then returns to idle with the ones count cleared, so the next packet decodes from scratch.
- R9: An SE1 sampled inside a packet raises `sym_o` (code 3) and `err_o` and returns to idle. An SE1 appearing while idle raises `err_o` alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, OSR cycles per bit time |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Raw D+ wire |
| dm_i | input | 1 | Raw D- wire |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| sop_o | output | 1 | Start-of-packet strobe |
| sym_o | output | 1 | Sampled-symbol strobe |
| sym_code_o | output | 2 | Code of the last sampled symbol (J=0, K=1, SE0=2, SE1=3) |
| bit_o | output | 1 | Data-bit strobe |
| bit_val_o | output | 1 | Value of the data bit |
| stuff_o | output | 1 | Stuff-bit strobe |
| eop_o | output | 1 | End-of-packet strobe |
| err_o | output | 1 | SE1 error strobe |

## Verification
Each result has a fixed latency from a wire change:
- Two synchroniser stages and one output register put `sop_o` and `err_o` (idle case) 3 cycles after the change.
- Every sampled-symbol result lands 3+OSR/2 cycles after the latest symbol change, and then every OSR cycles.

The bench drives wires on falling edges, counts rising edges, and logs every strobe with its cycle number on the falling edge. It compares the logged event order against a sequence computed from an independent NRZI and bit-stuffing encoder. It also checks the two latencies exactly on the first packet. Packets sweep both speeds, one- and two-bit SE0, and payloads that force stuffing, SE1 faults and idle lines.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_J   = 2'd0,
        SYM_K   = 2'd1,
        SYM_SE0 = 2'd2,
        SYM_SE1 = 2'd3
    } line_sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_EOPW = 2'd2
    } rx_state_e;

    // Wire pair to symbol; the J/K meaning flips with the speed select.
    function automatic line_sym_e classify(input logic dp, input logic dm,
                                           input logic low_speed);
        line_sym_e s;
        unique case ({dp, dm})
            2'b00:   s = SYM_SE0;
            2'b11:   s = SYM_SE1;
            2'b10:   s = low_speed ? SYM_K : SYM_J;
            default: s = low_speed ? SYM_J : SYM_K;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe_q[g] <= '0;
                    else         pipe_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) pipe_q[g] <= '0;
                    else         pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/usbrx_phase.sv
module usbrx_phase
    import usbrx_pkg::*;
#(
    parameter int OSR = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  line_sym_e sym_i,
    output logic      edge_o,
    output logic      sample_o
);

    localparam int CW = $clog2(OSR + 1);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    line_sym_e       prev_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   pos;

    always_comb begin
        edge_o   = (sym_i != prev_q);
        pos      = edge_o ? '0 : cnt_q;
        sample_o = (pos == HALF);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= SYM_SE0;
            cnt_q  <= '0;
        end else begin
            prev_q <= sym_i;
            cnt_q  <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/usbrx_fsm.sv
module usbrx_fsm
    import usbrx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  line_sym_e  sym_i,
    input  logic       edge_i,
    input  logic       sample_i,
    output logic       sop_o,
    output logic       sym_o,
    output logic [1:0] sym_code_o,
    output logic       bit_o,
    output logic       bit_val_o,
    output logic       stuff_o,
    output logic       eop_o,
    output logic       err_o
);

    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [OW-1:0] ONES_MAX = OW'(STUFF_RUN);

    rx_state_e     state_q, state_d;
    line_sym_e     last_q, last_d;
    logic [OW-1:0] ones_q, ones_d;
    logic          sop_d, sym_d, bit_d, val_d, stuff_d, eop_d, err_d;
    logic          same;

    always_comb begin
        state_d = state_q;
        last_d  = last_q;
        ones_d  = ones_q;
        sop_d   = 1'b0;
        sym_d   = 1'b0;
        bit_d   = 1'b0;
        val_d   = 1'b0;
        stuff_d = 1'b0;
        eop_d   = 1'b0;
        err_d   = 1'b0;
        same    = (sym_i == last_q);
        unique case (state_q)
            ST_IDLE: begin
                last_d = SYM_J;
                ones_d = '0;
                if (edge_i) begin
                    if (sym_i == SYM_K) begin
                        sop_d   = 1'b1;
                        state_d = ST_BITS;
                    end else if (sym_i == SYM_SE1) begin
                        err_d = 1'b1;
                    end
                end
            end
            ST_BITS: begin
                if (sample_i) begin
                    sym_d = 1'b1;
                    unique case (sym_i)
                        SYM_J, SYM_K: begin
                            last_d = sym_i;
                            if (ones_q == ONES_MAX && !same) begin
                                stuff_d = 1'b1;
                                ones_d  = '0;
                            end else begin
                                bit_d = 1'b1;
                                val_d = same;
                                if (!same)                 ones_d = '0;
                                else if (ones_q != ONES_MAX) ones_d = ones_q + 1'b1;
                            end
                        end
                        SYM_SE0: state_d = ST_EOPW;
                        SYM_SE1: begin
                            err_d   = 1'b1;
                            state_d = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_EOPW: begin
                if (sample_i) begin
                    sym_d = 1'b1;
                    unique case (sym_i)
                        SYM_J: begin
                            eop_d   = 1'b1;
                            ones_d  = '0;
                            state_d = ST_IDLE;
                        end
                        SYM_SE1: begin
                            err_d   = 1'b1;
                            state_d = ST_IDLE;
                        end
                        SYM_SE0, SYM_K: ;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            last_q  <= SYM_J;
            ones_q  <= '0;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
            ones_q  <= ones_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sop_o      <= 1'b0;
            sym_o      <= 1'b0;
            sym_code_o <= 2'd0;
            bit_o      <= 1'b0;
            bit_val_o  <= 1'b0;
            stuff_o    <= 1'b0;
            eop_o      <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            sop_o     <= sop_d;
            sym_o     <= sym_d;
            bit_o     <= bit_d;
            bit_val_o <= val_d;
            stuff_o   <= stuff_d;
            eop_o     <= eop_d;
            err_o     <= err_d;
            if (sym_d) sym_code_o <= sym_i;
        end
    end

endmodule

// File: rtl/usbrx_top.sv
module usbrx_top
    import usbrx_pkg::*;
#(
    parameter int OSR       = 4,
    parameter int STUFF_RUN = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic       low_speed_i,
    output logic       sop_o,
    output logic       sym_o,
    output logic [1:0] sym_code_o,
    output logic       bit_o,
    output logic       bit_val_o,
    output logic       stuff_o,
    output logic       eop_o,
    output logic       err_o
);

    logic [1:0] wires_s;
    line_sym_e  sym;
    logic       sym_edge;
    logic       sample;

    usbrx_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dp_i, dm_i}),
        .sync_o  (wires_s)
    );

    assign sym = classify(wires_s[1], wires_s[0], low_speed_i);

    usbrx_phase #(.OSR(OSR)) u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sym_i    (sym),
        .edge_o   (sym_edge),
        .sample_o (sample)
    );

    usbrx_fsm #(.STUFF_RUN(STUFF_RUN)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sym_i      (sym),
        .edge_i     (sym_edge),
        .sample_i   (sample),
        .sop_o      (sop_o),
        .sym_o      (sym_o),
        .sym_code_o (sym_code_o),
        .bit_o      (bit_o),
        .bit_val_o  (bit_val_o),
        .stuff_o    (stuff_o),
        .eop_o      (eop_o),
        .err_o      (err_o)
    );

endmodule

// File: rtl/usbrx_chk.sv
module usbrx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sop_o,
    input logic       sym_o,
    input logic [1:0] sym_code_o,
    input logic       bit_o,
    input logic       stuff_o,
    input logic       eop_o,
    input logic       err_o
);

    p_sop_alone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sop_o |-> (!sym_o && !err_o));

    p_sym_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sym_o |=> !sym_o);

    p_bit_on_jk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_o |-> (sym_o && !sym_code_o[1]));

    p_stuff_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stuff_o |-> (sym_o && !bit_o && !sym_code_o[1]));

    p_se_no_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sym_o && sym_code_o[1]) |-> (!bit_o && !stuff_o));

    p_eop_on_j_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |-> (sym_o && sym_code_o == 2'd0 && !bit_o));

    p_err_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> (!bit_o && !stuff_o && !eop_o));

endmodule

bind usbrx_top usbrx_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sop_o      (sop_o),
    .sym_o      (sym_o),
    .sym_code_o (sym_code_o),
    .bit_o      (bit_o),
    .stuff_o    (stuff_o),
    .eop_o      (eop_o),
    .err_o      (err_o)
);

// File: tb/usbrx_top_tb.sv
module usbrx_top_tb;

    localparam int OSR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b1, dm = 1'b0, ls = 1'b0;
    logic sop, sym, bitv, bval, stuff, eop, err;
    logic [1:0] code;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int log_code[$];
    int log_cyc[$];
    int exp_q[$];
    int line = 0;
    int ones = 0;
    int stim_cyc = 0;
    bit first_pending = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usbrx_top #(.OSR(OSR), .STUFF_RUN(6)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
        .sop_o(sop), .sym_o(sym), .sym_code_o(code), .bit_o(bitv),
        .bit_val_o(bval), .stuff_o(stuff), .eop_o(eop), .err_o(err)
    );

    // Event log, fixed order within a cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (sop)   begin log_code.push_back(40);            log_cyc.push_back(cyc); end
            if (sym)   begin log_code.push_back(10 + int'(code)); log_cyc.push_back(cyc); end
            if (bitv)  begin log_code.push_back(20 + int'(bval)); log_cyc.push_back(cyc); end
            if (stuff) begin log_code.push_back(30);            log_cyc.push_back(cyc); end
            if (eop)   begin log_code.push_back(50);            log_cyc.push_back(cyc); end
            if (err)   begin log_code.push_back(60);            log_cyc.push_back(cyc); end
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Symbol codes: 0=J 1=K 2=SE0 3=SE1 (R1 wire mapping)
    task automatic put_sym(input int s);
        case (s)
            0: begin dp = !ls; dm = ls;  end
            1: begin dp = ls;  dm = !ls; end
            2: begin dp = 1'b0; dm = 1'b0; end
            default: begin dp = 1'b1; dm = 1'b1; end
        endcase
        repeat (OSR) @(negedge clk);
    endtask

    task automatic clear_logs();
        log_code.delete();
        log_cyc.delete();
        exp_q.delete();
    endtask

    // NRZI encoder with stuffing, building the expected events (R5, R6)
    task automatic send_bit(input int b);
        if (b == 0) line ^= 1;
        exp_q.push_back(10 + line);
        exp_q.push_back(20 + b);
        if (first_pending) begin
            stim_cyc = cyc;
            first_pending = 1'b0;
        end
        put_sym(line);
        if (b == 1) begin
            ones++;
            if (ones == 6) begin
                line ^= 1;
                exp_q.push_back(10 + line);
                exp_q.push_back(30);
                put_sym(line);
                ones = 0;
            end
        end else begin
            ones = 0;
        end
    endtask

    task automatic compare(input string req);
        check(log_code.size() == exp_q.size(), req, log_code.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < log_code.size())
                check(log_code[i] == exp_q[i], req, log_code[i], exp_q[i]);
        end
    endtask

    task automatic set_speed(input logic new_ls);
        if (new_ls != ls) begin
            put_sym(2);
            ls = new_ls;
        end
        repeat (3) put_sym(0);
    endtask

    function automatic logic [15:0] payload(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'hA5C3;
            3: return 16'h7FFE;
            4: return 16'h00FF;
            default: return 16'h3F81;
        endcase
    endfunction

    task automatic send_packet(input logic spd, input logic [15:0] pl,
                               input int se0_len, input bit measure);
        set_speed(spd);
        clear_logs();
        line = 0;
        ones = 0;
        exp_q.push_back(40);
        first_pending = 1'b1;
        for (int i = 0; i < 8; i++) send_bit(i == 7 ? 1 : 0);
        for (int i = 0; i < 16; i++) send_bit(int'(pl[i]));
        for (int i = 0; i < se0_len; i++) begin
            exp_q.push_back(12);
            put_sym(2);
        end
        exp_q.push_back(10);
        exp_q.push_back(50);
        line = 0;
        repeat (4) put_sym(0);
        compare("R1/R5/R6/R7/R8 packet");
        if (measure && log_cyc.size() >= 2) begin
            check(log_cyc[0] - stim_cyc == 3, "R3 sop latency", log_cyc[0] - stim_cyc, 3);
            check(log_cyc[1] - stim_cyc == 3 + OSR / 2, "R4 sample latency",
                  log_cyc[1] - stim_cyc, 3 + OSR / 2);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R2: reset state
        check({sop, sym, bitv, stuff, eop, err} == 6'b0, "R2 reset", 1, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        // R2: long idle J yields nothing
        check(log_code.size() == 0, "R2 idle", log_code.size(), 0);

        // Sweep: both speeds, SE0 of one and two bits, six payloads
        for (int s = 0; s < 2; s++)
            for (int e = 1; e <= 2; e++)
                for (int k = 0; k < 6; k++)
                    send_packet(s[0], payload(k), e, (s == 0 && e == 1 && k == 0));

        // R9: SE1 inside a packet, then SE1 while idle
        set_speed(1'b0);
        clear_logs();
        line = 0;
        ones = 0;
        exp_q.push_back(40);
        for (int i = 0; i < 3; i++) send_bit(0);
        exp_q.push_back(13);
        exp_q.push_back(60);
        put_sym(3);
        repeat (3) put_sym(0);
        exp_q.push_back(60);
        put_sym(3);
        repeat (3) put_sym(0);
        compare("R9 se1");

        // R8: after error, a clean packet still decodes from scratch
        send_packet(1'b0, 16'hFFFF, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule